// File: doc/BRIEF.md
# Power-On Reset and Boot Vector Fetch Sequencer

This block brings a processor subsystem out of power-up. It watches a supply-good signal from an external comparator. While the supply is bad, it holds every register it controls at its default value and drops the active-low reset. It also gives the fabric a slow clock enable, derived from the free-running internal oscillator. The supply-good level is first resynchronised. Once it has stayed high for a programmable number of oscillator cycles, the reset output rises. The block then reads two words from boot memory over a valid/ready port. The word at the base address is the initial stack pointer and the next word is the entry address of the reset handler.

When both words have been captured, the entry address is checked. If its low bit is 1, which marks a valid code entry, both words are presented to the core together with a one-cycle start strobe. If the bit is 0, a sticky fault flag rises instead and no strobe is ever given. Any drop of supply-good clears the block at once, asynchronously, and the whole sequence restarts when the supply returns.

Top module: `por_boot_seq`

## Requirements
- R1: While supply_good_i is low, por_n_o, rd_valid_o, start_o and vec_fault_o are 0 and sp_o and pc_o are 0, without waiting for a clock edge.
- R2: Count as edge 1 the first rising clock edge at which supply_good_i is high. por_n_o rises after edge SYNC_STAGES+1+S, where S is the value on settle_cycles_i, provided supply_good_i stays high throughout.
- R3: A drop of supply_good_i at any point before release discards the settle progress, and the full R2 delay applies again from the next rise.
- R4: While por_n_o is low, fab_ce_o is high for one cycle out of every RST_DIV cycles.
- R5: While por_n_o is high, fab_ce_o is high for one cycle out of every RUN_DIV cycles.
- R6: In the first cycle after release, rd_valid_o rises with rd_addr_o = BOOT_BASE. The request and its address hold until a cycle with rd_ready_i high.
- R7: In the cycle after the first read is accepted, the second request presents rd_addr_o = BOOT_BASE + DW/8, and it too holds until accepted.
- R8: sp_o carries the data accepted by the first read and pc_o the data accepted by the second. Both hold from the start strobe onward.
- R9: If bit 0 of the second word is 1, start_o is high for exactly the one cycle after the second read is accepted, and never again until the next power-up.
- R10: If bit 0 of the second word is 0, vec_fault_o rises in the cycle after acceptance and stays high, and start_o never rises.
- R11: After the second read is accepted, rd_valid_o stays low until the next power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| supply_good_i | input | 1 | Comparator output, high when the core supply is above threshold (asynchronous) |
| settle_cycles_i | input | CNT_W | Extra cycles supply-good must hold before release |
| por_n_o | output | 1 | Active-low system reset |
| fab_ce_o | output | 1 | Fabric clock enable (divided oscillator) |
| rd_valid_o | output | 1 | Boot memory read request |
| rd_addr_o | output | AW | Boot memory byte address |
| rd_ready_i | input | 1 | Read accepted; rd_data_i is valid in this cycle |
| rd_data_i | input | DW | Read data |
| sp_o | output | DW | Initial stack pointer |
| pc_o | output | DW | Reset handler entry address |
| start_o | output | 1 | One-cycle start strobe to the core |
| vec_fault_o | output | 1 | Sticky flag for an entry address with bit 0 clear |

## Verification
The bench builds the block with RUN_DIV=2 and keeps RST_DIV=4, SYNC_STAGES=2, DW=AW=32 and BOOT_BASE=0. Because the two ratios differ, the divider's selecting variant is the one built, and the bench can see fab_ce_o change rate at each release and each supply drop. An 8-bit settle count lets the bench cover the zero-settle boundary as well as longer holds, and lets it drop the supply part-way through a settle. Memory wait states from zero to several cycles check that the requests and their addresses are held.

// File: rtl/por_boot_pkg.sv
package por_boot_pkg;

   typedef enum logic [2:0] {
      ST_HOLD     = 3'd0,
      ST_FETCH_SP = 3'd1,
      ST_FETCH_PC = 3'd2,
      ST_START    = 3'd3,
      ST_RUN      = 3'd4,
      ST_FAULT    = 3'd5
   } boot_state_e;

   function automatic int unsigned ratio_width(input int unsigned a, input int unsigned b);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m < 2) ? 1 : $clog2(m);
   endfunction

endpackage

// File: rtl/por_supply_sync.sv
module por_supply_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_n_i,
   output logic good_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("por_supply_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge arst_n_i) begin
         if (!arst_n_i) begin
            chain_q[i] <= 1'b0;
         end else begin
            chain_q[i] <= (i == 0) ? 1'b1 : chain_q[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign good_o = chain_q[STAGES-1];

endmodule

// File: rtl/por_clk_div.sv
module por_clk_div
   import por_boot_pkg::*;
#(
   parameter int unsigned RST_DIV = 4,
   parameter int unsigned RUN_DIV = 1
) (
   input  logic clk_i,
   input  logic in_reset_i,
   output logic tick_o
);

   localparam int unsigned DIVW = ratio_width(RST_DIV, RUN_DIV);
   localparam logic [DIVW:0] RST_LAST = DIVW'(RST_DIV - 1);
   localparam logic [DIVW:0] RUN_LAST = DIVW'(RUN_DIV - 1);

   if (RST_DIV < 1 || RUN_DIV < 1) begin : g_bad_ratio
      $error("por_clk_div: division ratios must be at least 1");
   end

   // Runs from the oscillator without a reset so that it keeps ticking
   // while the supply is bad; the >= compare recovers from any count.
   logic [DIVW:0] cnt_q;
   logic [DIVW:0] last;

   if (RST_DIV == RUN_DIV) begin : g_fixed
      assign last = RST_LAST;
   end else begin : g_select
      assign last = in_reset_i ? RST_LAST : RUN_LAST;
   end

   assign tick_o = (cnt_q >= last);

   always_ff @(posedge clk_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/por_fetch_fsm.sv
module por_fetch_fsm
   import por_boot_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned DW        = 32,
   parameter int unsigned AW        = 32,
   parameter logic [AW-1:0] BOOT_BASE = '0
) (
   input  logic             clk_i,
   input  logic             arst_n_i,
   input  logic             good_sync_i,
   input  logic [CNT_W-1:0] settle_i,
   output logic             rd_valid_o,
   output logic [AW-1:0]    rd_addr_o,
   input  logic             rd_ready_i,
   input  logic [DW-1:0]    rd_data_i,
   output logic [DW-1:0]    sp_o,
   output logic [DW-1:0]    pc_o,
   output logic             start_o,
   output logic             fault_o,
   output logic             por_n_o
);

   localparam logic [AW-1:0] WORD_STEP = AW'(DW / 8);

   boot_state_e      state_q;
   logic [CNT_W-1:0] settle_q;
   logic [DW-1:0]    sp_q;
   logic [DW-1:0]    pc_q;

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) begin
         state_q  <= ST_HOLD;
         settle_q <= '0;
         sp_q     <= '0;
         pc_q     <= '0;
      end else begin
         unique case (state_q)
            ST_HOLD: begin
               if (good_sync_i) begin
                  if (settle_q == settle_i) begin
                     state_q <= ST_FETCH_SP;
                  end else begin
                     settle_q <= settle_q + 1'b1;
                  end
               end
            end
            ST_FETCH_SP: begin
               if (rd_ready_i) begin
                  sp_q    <= rd_data_i;
                  state_q <= ST_FETCH_PC;
               end
            end
            ST_FETCH_PC: begin
               if (rd_ready_i) begin
                  pc_q    <= rd_data_i;
                  state_q <= rd_data_i[0] ? ST_START : ST_FAULT;
               end
            end
            ST_START: state_q <= ST_RUN;
            ST_RUN:   state_q <= ST_RUN;
            ST_FAULT: state_q <= ST_FAULT;
            default:  state_q <= ST_HOLD;
         endcase
      end
   end

   assign por_n_o    = (state_q != ST_HOLD);
   assign rd_valid_o = (state_q == ST_FETCH_SP) || (state_q == ST_FETCH_PC);
   assign rd_addr_o  = (state_q == ST_FETCH_PC) ? BOOT_BASE + WORD_STEP : BOOT_BASE;
   assign start_o    = (state_q == ST_START);
   assign fault_o    = (state_q == ST_FAULT);
   assign sp_o       = sp_q;
   assign pc_o       = pc_q;

endmodule

// File: rtl/por_boot_seq.sv
module por_boot_seq
   import por_boot_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_DIV     = 4,
   parameter int unsigned RUN_DIV     = 1,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned DW          = 32,
   parameter int unsigned AW          = 32,
   parameter logic [AW-1:0] BOOT_BASE = '0
) (
   input  logic             clk_i,
   input  logic             supply_good_i,
   input  logic [CNT_W-1:0] settle_cycles_i,
   output logic             por_n_o,
   output logic             fab_ce_o,
   output logic             rd_valid_o,
   output logic [AW-1:0]    rd_addr_o,
   input  logic             rd_ready_i,
   input  logic [DW-1:0]    rd_data_i,
   output logic [DW-1:0]    sp_o,
   output logic [DW-1:0]    pc_o,
   output logic             start_o,
   output logic             vec_fault_o
);

   if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
      $error("por_boot_seq: DW must be a whole number of bytes");
   end
   if (AW < 4) begin : g_bad_aw
      $error("por_boot_seq: AW too small for two word addresses");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("por_boot_seq: CNT_W must be at least 1");
   end

   logic good_sync;

   por_supply_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i    (clk_i),
      .arst_n_i (supply_good_i),
      .good_o   (good_sync)
   );

   por_fetch_fsm #(
      .CNT_W     (CNT_W),
      .DW        (DW),
      .AW        (AW),
      .BOOT_BASE (BOOT_BASE)
   ) u_fsm (
      .clk_i       (clk_i),
      .arst_n_i    (supply_good_i),
      .good_sync_i (good_sync),
      .settle_i    (settle_cycles_i),
      .rd_valid_o  (rd_valid_o),
      .rd_addr_o   (rd_addr_o),
      .rd_ready_i  (rd_ready_i),
      .rd_data_i   (rd_data_i),
      .sp_o        (sp_o),
      .pc_o        (pc_o),
      .start_o     (start_o),
      .fault_o     (vec_fault_o),
      .por_n_o     (por_n_o)
   );

   por_clk_div #(
      .RST_DIV (RST_DIV),
      .RUN_DIV (RUN_DIV)
   ) u_div (
      .clk_i      (clk_i),
      .in_reset_i (!por_n_o),
      .tick_o     (fab_ce_o)
   );

endmodule

// File: rtl/por_boot_seq_chk.sv
module por_boot_seq_chk #(
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 32,
   parameter logic [AW-1:0] BOOT_BASE = '0
) (
   input logic          clk_i,
   input logic          supply_good_i,
   input logic          por_n_o,
   input logic          rd_valid_o,
   input logic [AW-1:0] rd_addr_o,
   input logic          rd_ready_i,
   input logic [DW-1:0] pc_o,
   input logic          start_o,
   input logic          vec_fault_o
);

   localparam logic [AW-1:0] SECOND = BOOT_BASE + AW'(DW / 8);

   // R1: held in reset while the supply is bad
   p_reset_when_bad_r1: assert property (@(posedge clk_i)
      !supply_good_i |-> (!por_n_o && !rd_valid_o && !start_o && !vec_fault_o));

   // R6: a waiting request keeps its address
   p_req_held_r6: assert property (@(posedge clk_i) disable iff (!supply_good_i)
      (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

   // R6: no fetch while reset is still asserted
   p_fetch_after_release_r6: assert property (@(posedge clk_i) disable iff (!supply_good_i)
      rd_valid_o |-> por_n_o);

   // R7: first accept leads straight to the second address
   p_second_addr_r7: assert property (@(posedge clk_i) disable iff (!supply_good_i)
      (rd_valid_o && rd_ready_i && rd_addr_o == BOOT_BASE) |=> (rd_valid_o && rd_addr_o == SECOND));

   // R9: start lasts one cycle
   p_start_single_r9: assert property (@(posedge clk_i) disable iff (!supply_good_i)
      start_o |=> !start_o);

   // R9: start only with an odd entry address
   p_start_odd_r9: assert property (@(posedge clk_i) disable iff (!supply_good_i)
      start_o |-> pc_o[0]);

   // R10: fault is sticky and excludes start
   p_fault_sticky_r10: assert property (@(posedge clk_i) disable iff (!supply_good_i)
      vec_fault_o |=> (vec_fault_o && !start_o));

   // R11: no further reads after the start strobe
   p_no_read_after_r11: assert property (@(posedge clk_i) disable iff (!supply_good_i)
      start_o |=> !rd_valid_o);

endmodule

bind por_boot_seq por_boot_seq_chk #(
   .DW        (DW),
   .AW        (AW),
   .BOOT_BASE (BOOT_BASE)
) u_chk (
   .clk_i         (clk_i),
   .supply_good_i (supply_good_i),
   .por_n_o       (por_n_o),
   .rd_valid_o    (rd_valid_o),
   .rd_addr_o     (rd_addr_o),
   .rd_ready_i    (rd_ready_i),
   .pc_o          (pc_o),
   .start_o       (start_o),
   .vec_fault_o   (vec_fault_o)
);

// File: tb/por_boot_seq_tb.sv
module por_boot_seq_tb;

   localparam int unsigned SYNC = 2;
   localparam int unsigned RSTD = 4;
   localparam int unsigned RUND = 2;
   localparam int unsigned CW   = 8;
   localparam int unsigned DW   = 32;
   localparam int unsigned AW   = 32;

   logic          clk = 1'b0;
   logic          supply_good = 1'b0;
   logic [CW-1:0] settle = '0;
   logic          por_n, fab_ce, rd_valid, rd_ready, start, vfault;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data, sp, pc;

   por_boot_seq #(
      .SYNC_STAGES (SYNC), .RST_DIV (RSTD), .RUN_DIV (RUND),
      .CNT_W (CW), .DW (DW), .AW (AW), .BOOT_BASE ('0)
   ) u_dut (
      .clk_i (clk), .supply_good_i (supply_good), .settle_cycles_i (settle),
      .por_n_o (por_n), .fab_ce_o (fab_ce), .rd_valid_o (rd_valid),
      .rd_addr_o (rd_addr), .rd_ready_i (rd_ready), .rd_data_i (rd_data),
      .sp_o (sp), .pc_o (pc), .start_o (start), .vec_fault_o (vfault)
   );

   always #10 clk = ~clk;

   int total = 0;
   int bad   = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Memory responder
   logic [DW-1:0] sp_word = '0, pc_word = '0;
   int gap = 0, gap_cnt = 0;

   // Behavioural reference: phase 0 hold,1 fetch sp,2 fetch pc,3 start,4 run,5 fault
   int m_phase = 0, m_hi = 0, m_settle = 0;
   logic [DW-1:0] m_sp = '0, m_pc = '0;
   int starts = 0, faults_seen = 0;

   always @(posedge clk) begin
      if (!supply_good) begin
         m_phase = 0; m_hi = 0; m_settle = 0; m_sp = '0; m_pc = '0;
      end else begin
         m_hi++;
         case (m_phase)
            0: if (m_hi >= SYNC + 1) begin
                  if (m_settle == int'(settle)) m_phase = 1;
                  else m_settle++;
               end
            1: if (rd_ready) begin m_sp = rd_data; m_phase = 2; end
            2: if (rd_ready) begin m_pc = rd_data; m_phase = rd_data[0] ? 3 : 5; end
            3: m_phase = 4;
            default: ;
         endcase
      end
   end

   // Divider interval tracking
   int cyc = 0, last_tick = -1, last_tick_seg = -1, seg = 0;
   logic prev_por = 1'b0;

   always @(negedge clk) begin
      cyc++;
      // per-clock comparison with the reference
      chk("R2 por_n", por_n, m_phase != 0);
      chk("R6 rd_valid", rd_valid, (m_phase == 1) || (m_phase == 2));
      if (m_phase == 1) chk("R6 addr", rd_addr, 0);
      if (m_phase == 2) chk("R7 addr", rd_addr, DW / 8);
      chk("R9 start", start, m_phase == 3);
      chk("R10 fault", vfault, m_phase == 5);
      chk("R8 sp", sp, m_sp);
      chk("R8 pc", pc, m_pc);
      if (m_phase >= 3) chk("R11 no read", rd_valid, 0);
      if (start) starts++;
      if (vfault) faults_seen++;
      // R4/R5 divider spacing, only between ticks within one reset phase
      if (por_n !== prev_por) seg++;
      prev_por = por_n;
      if (fab_ce) begin
         if (last_tick >= 0 && last_tick_seg == seg) begin
            if (por_n) chk("R5 run divide", cyc - last_tick, RUND);
            else       chk("R4 reset divide", cyc - last_tick, RSTD);
         end
         last_tick = cyc; last_tick_seg = seg;
      end
      // drive memory response
      if (rd_valid) begin
         if (gap_cnt == 0) begin rd_ready <= 1'b1; gap_cnt = gap; end
         else begin rd_ready <= 1'b0; gap_cnt--; end
         rd_data <= (rd_addr == 0) ? sp_word : pc_word;
      end else begin
         rd_ready <= 1'b0; gap_cnt = gap; rd_data <= '0;
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #2;
   endtask

   task automatic power_up(input int s, input int g, input logic [DW-1:0] spw, input logic [DW-1:0] pcw);
      settle = CW'(s); gap = g; gap_cnt = g; sp_word = spw; pc_word = pcw;
      supply_good = 1'b1;
   endtask

   // Measures the release delay after a rise at negedge+2 (R2)
   task automatic check_release(input int s);
      int n;
      n = 0;
      while (!por_n && n < 300) begin @(negedge clk); n++; end
      chk("R2 release delay", n, SYNC + 1 + s);
   endtask

   initial begin
      rd_ready = 1'b0; rd_data = '0;
      // R1/R4: held in reset with supply bad
      wait_cyc(20);
      chk("R1 por_n low", por_n, 0);
      chk("R1 no request", rd_valid, 0);
      chk("R1 sp default", sp, 0);

      // Scenario A: settle 3, no wait states, valid entry
      @(negedge clk); #2;
      power_up(3, 0, 32'h2000_8000, 32'h0000_1235);
      check_release(3);
      wait_cyc(15);
      chk("R9 one start A", starts, 1);
      chk("R8 pc A", pc, 32'h0000_1235);
      chk("R8 sp A", sp, 32'h2000_8000);

      // R1: asynchronous drop
      supply_good = 1'b0; #1;
      chk("R1 async por_n", por_n, 0);
      chk("R1 async pc", pc, 0);
      wait_cyc(10);

      // R3: drop part-way through settle, then full delay again
      supply_good = 1'b1; settle = 8'd6;
      wait_cyc(5);
      chk("R3 still held", por_n, 0);
      supply_good = 1'b0;
      wait_cyc(3);
      starts = 0;
      power_up(6, 3, 32'h1FFF_FFF0, 32'h0000_0401);
      check_release(6);
      wait_cyc(30);
      chk("R9 one start B", starts, 1);
      chk("R8 sp B", sp, 32'h1FFF_FFF0);

      // R10: even entry address, fault and no start
      supply_good = 1'b0;
      wait_cyc(8);
      starts = 0; faults_seen = 0;
      power_up(2, 1, 32'h2000_0100, 32'h0000_2000);
      check_release(2);
      wait_cyc(40);
      chk("R10 no start", starts, 0);
      chk("R10 fault sticky", vfault, 1);
      chk("R11 idle after fault", rd_valid, 0);

      // S = 0 boundary, long wait states
      supply_good = 1'b0;
      wait_cyc(8);
      starts = 0;
      power_up(0, 5, 32'hCAFE_0000, 32'hFFFF_FFFF);
      check_release(0);
      wait_cyc(40);
      chk("R9 one start zero settle", starts, 1);
      chk("R8 pc all ones", pc, 32'hFFFF_FFFF);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 20000);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule